// File: doc/BRIEF.md
# Pending Write Snoop Takeover Unit

This unit sits inside the external agent that bridges a processor to a shared system bus. When the processor hands over a dirty cache line for write-back, the unit captures the whole line (line-aligned address plus data) in one accepted cycle. From then on it is the owner of that line. It keeps ownership until the line has been forwarded onto the bus or given away to another bus agent.

While it owns the line, the unit watches every coherent read response on the bus and compares its line address with the held one. On a match it does not send an intervention to the processor. It treats the line as dirty exclusive, raises a takeover indication on the bus and streams the buffered data to the requester, one beat per cycle starting with the lowest beat. It then drops the buffered write, for shared and for exclusive reads alike, because data supplied this way also reaches memory. If it receives bus mastership first, it forwards the write instead. A match that arrives during that forwarding still wins and turns the transfer into a takeover.

Top module: `snoop_takeover_unit`

## Requirements
- R1: After reset, `wr_ready` is 1 and `takeover`, `resp_valid` and `fwd_valid` are 0.
- R2: A write is accepted in a cycle where `wr_valid` and `wr_ready` are both 1. From the next cycle `wr_ready` stays 0 until the held line is discarded or fully forwarded. `wr_valid` pulses while busy are ignored and do not change the held data.
- R3: Address comparison ignores the low OFF_W bits (line offset; 5 with defaults: 4 beats of 64 bits). `fwd_addr` is the accepted address with those bits zeroed.
- R4: A snoop with `snoop_valid`=1, kind 0 (shared read) or kind 1 (exclusive read) and a matching line address, seen while the line is held and not yet supplied, makes `takeover`=1 and `resp_valid`=1 from the next cycle for BEATS consecutive cycles. Beat i carries line bits [i*DATA_W +: DATA_W], and `resp_last` is set only on beat BEATS-1.
- R5: After the last supplied beat the buffered write is discarded for both read kinds. `wr_ready` is 1 in the following cycle, and no forward ever follows, even if a grant arrives.
- R6: A `bus_grant` while the line is held and no matching read is present starts forwarding in the next cycle. `fwd_valid`=1 for BEATS cycles with beats in ascending order and `fwd_last` on the final one. `wr_ready` returns to 1 in the cycle after the last beat.
- R7: A matching read during forwarding stops the forward: in the next cycle `fwd_valid` is 0 and the supply of R4 starts at beat 0. `resp_valid` and `fwd_valid` are never 1 together.
- R8: When a matching read and `bus_grant` arrive in the same cycle, the read wins: no forward happens and the supply of R4 starts.
- R9: Snoops with `snoop_valid`=0, snoops to another line, invalidates (kind 2), bus writes (kind 3), and any snoop while no line is held have no effect on the outputs.
- R10: A kind 2 or kind 3 snoop that matches the held line is illegal bus traffic and is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor offers a line write-back |
| wr_addr | input | ADDR_W | Byte address of the line |
| wr_line | input | BEATS*DATA_W | Whole line data, beat 0 in the low bits |
| wr_ready | output | 1 | Unit is empty and can accept a write |
| snoop_valid | input | 1 | Bus snoop qualifier |
| snoop_kind | input | 2 | 0 shared read, 1 exclusive read, 2 invalidate, 3 write |
| snoop_addr | input | ADDR_W | Snooped byte address |
| bus_grant | input | 1 | Bus mastership granted to the agent |
| takeover | output | 1 | Agent claims the snooped line on the bus |
| resp_valid | output | 1 | Takeover data beat valid |
| resp_data | output | DATA_W | Takeover data beat |
| resp_last | output | 1 | Final takeover beat |
| fwd_valid | output | 1 | Forwarded write beat valid |
| fwd_addr | output | ADDR_W | Line-aligned address of the forwarded write |
| fwd_data | output | DATA_W | Forwarded write beat |
| fwd_last | output | 1 | Final forwarded beat |

## Verification
Every response is due exactly one cycle after the stimulus edge. That covers the end of `wr_ready` after an accept, the first supply beat after a matching read, the first forward beat after a grant, and the switch from forwarding to supply. Each later beat follows one cycle after the one before it, and `wr_ready` returns one cycle after the last beat. The bench drives inputs on the falling edge and samples on the next falling edge, so every check reads the state that exactly one rising edge has produced. Per-beat expectations are computed from the randomly generated line and the beat index.

// File: rtl/tkv_pkg.sv
package tkv_pkg;

    // Snoop kind codes carried on the bus snoop input
    typedef enum logic [1:0] {
        SNP_RD_SHR = 2'd0,
        SNP_RD_EXC = 2'd1,
        SNP_INVAL  = 2'd2,
        SNP_WRITE  = 2'd3
    } snoop_kind_e;

    // Ownership state of the held line
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_HOLD   = 2'd1,
        ST_FWD    = 2'd2,
        ST_SUPPLY = 2'd3
    } hold_state_e;

    function automatic logic kind_is_read(input logic [1:0] kind);
        return (kind == SNP_RD_SHR) || (kind == SNP_RD_EXC);
    endfunction

endpackage

// File: rtl/tkv_line_match.sv
module tkv_line_match #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input  logic              held,
    input  logic [ADDR_W-1:0] held_addr,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_kind,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              hit_read,
    output logic              hit_illegal
);
    import tkv_pkg::*;

    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    logic same_line;

    always_comb begin
        same_line   = ((snoop_addr & LINE_MASK) == held_addr);
        hit_read    = held && snoop_valid && same_line && kind_is_read(snoop_kind);
        hit_illegal = held && snoop_valid && same_line && !kind_is_read(snoop_kind);
    end

endmodule

// File: rtl/tkv_line_buf.sv
module tkv_line_buf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    parameter int OFF_W  = 5,
    parameter int BEAT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [BEATS*DATA_W-1:0] in_line,
    input  logic [BEAT_W-1:0]       beat_sel,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [DATA_W-1:0]       beat_data
);
    localparam int LINE_W = BEATS * DATA_W;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] line;
    } buf_t;

    buf_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.addr = in_addr & LINE_MASK;
            r_d.line = in_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Beat selection: one lane per beat
    logic [DATA_W-1:0] lanes [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        assign lanes[g] = r_q.line[g*DATA_W +: DATA_W];
    end

    always_comb begin
        beat_data = '0;
        for (int i = 0; i < BEATS; i++) begin
            if (beat_sel == BEAT_W'(i)) begin
                beat_data = lanes[i];
            end
        end
    end

    assign addr_q = r_q.addr;

endmodule

// File: rtl/tkv_ctrl.sv
module tkv_ctrl #(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              hit_read,
    input  logic              bus_grant,
    output logic              wr_ready,
    output logic              load,
    output logic              held,
    output logic [BEAT_W-1:0] beat,
    output logic              supplying,
    output logic              forwarding,
    output logic              last_beat
);
    import tkv_pkg::*;

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        hold_state_e       state;
        logic [BEAT_W-1:0] beat;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        unique case (r_q.state)
            ST_EMPTY: begin
                if (wr_valid) begin
                    load      = 1'b1;
                    r_d.state = ST_HOLD;
                    r_d.beat  = '0;
                end
            end
            ST_HOLD: begin
                // A conflicting read outranks a grant in the same cycle
                if (hit_read) begin
                    r_d.state = ST_SUPPLY;
                    r_d.beat  = '0;
                end else if (bus_grant) begin
                    r_d.state = ST_FWD;
                    r_d.beat  = '0;
                end
            end
            ST_FWD: begin
                if (hit_read) begin
                    r_d.state = ST_SUPPLY;
                    r_d.beat  = '0;
                end else if (r_q.beat == LAST_BEAT) begin
                    r_d.state = ST_EMPTY;
                    r_d.beat  = '0;
                end else begin
                    r_d.beat = r_q.beat + BEAT_W'(1);
                end
            end
            ST_SUPPLY: begin
                if (r_q.beat == LAST_BEAT) begin
                    // Data handed to the requester: the write is dropped
                    r_d.state = ST_EMPTY;
                    r_d.beat  = '0;
                end else begin
                    r_d.beat = r_q.beat + BEAT_W'(1);
                end
            end
            default: begin
                r_d.state = ST_EMPTY;
                r_d.beat  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_EMPTY;
            r_q.beat  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_ready   = (r_q.state == ST_EMPTY);
    assign held       = (r_q.state == ST_HOLD) || (r_q.state == ST_FWD);
    assign supplying  = (r_q.state == ST_SUPPLY);
    assign forwarding = (r_q.state == ST_FWD);
    assign beat       = r_q.beat;
    assign last_beat  = (r_q.beat == LAST_BEAT);

endmodule

// File: rtl/snoop_takeover_unit.sv
module snoop_takeover_unit #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BEATS*DATA_W-1:0] wr_line,
    output logic                    wr_ready,
    input  logic                    snoop_valid,
    input  logic [1:0]              snoop_kind,
    input  logic [ADDR_W-1:0]       snoop_addr,
    input  logic                    bus_grant,
    output logic                    takeover,
    output logic                    resp_valid,
    output logic [DATA_W-1:0]       resp_data,
    output logic                    resp_last,
    output logic                    fwd_valid,
    output logic [ADDR_W-1:0]       fwd_addr,
    output logic [DATA_W-1:0]       fwd_data,
    output logic                    fwd_last
);
    localparam int LINE_BYTES = BEATS * DATA_W / 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic              ready_w;
    logic              load;
    logic              held;
    logic [BEAT_W-1:0] beat;
    logic              supplying;
    logic              forwarding;
    logic              last_beat;
    logic              hit_read;
    logic              hit_illegal;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] beat_data;

    tkv_ctrl #(
        .BEATS  (BEATS),
        .BEAT_W (BEAT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .hit_read   (hit_read),
        .bus_grant  (bus_grant),
        .wr_ready   (ready_w),
        .load       (load),
        .held       (held),
        .beat       (beat),
        .supplying  (supplying),
        .forwarding (forwarding),
        .last_beat  (last_beat)
    );

    tkv_line_buf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS),
        .OFF_W  (OFF_W),
        .BEAT_W (BEAT_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .in_addr   (wr_addr),
        .in_line   (wr_line),
        .beat_sel  (beat),
        .addr_q    (held_addr),
        .beat_data (beat_data)
    );

    tkv_line_match #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_match (
        .held        (held),
        .held_addr   (held_addr),
        .snoop_valid (snoop_valid),
        .snoop_kind  (snoop_kind),
        .snoop_addr  (snoop_addr),
        .hit_read    (hit_read),
        .hit_illegal (hit_illegal)
    );

    // Illegal matches are reported by the bound checker; no state reacts
    logic unused_ok;
    assign unused_ok = hit_illegal;

    assign wr_ready   = ready_w;
    assign takeover   = supplying;
    assign resp_valid = supplying;
    assign resp_last  = supplying && last_beat;
    assign resp_data  = supplying ? beat_data : '0;
    assign fwd_valid  = forwarding;
    assign fwd_last   = forwarding && last_beat;
    assign fwd_data   = forwarding ? beat_data : '0;
    assign fwd_addr   = held_addr;

endmodule

// File: rtl/tkv_checker.sv
module tkv_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              snoop_valid,
    input logic [1:0]        snoop_kind,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              bus_grant,
    input logic              takeover,
    input logic              resp_valid,
    input logic              resp_last,
    input logic              fwd_valid
);
    localparam logic [ADDR_W-1:0] MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    logic [ADDR_W-1:0] cap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (wr_valid && wr_ready) begin
            cap_q <= wr_addr & MASK;
        end
    end

    logic owned, same, rd_hit, bad_hit;
    assign owned   = !wr_ready && !resp_valid;
    assign same    = (snoop_addr & MASK) == cap_q;
    assign rd_hit  = owned && snoop_valid && same && !snoop_kind[1];
    assign bad_hit = owned && snoop_valid && same && snoop_kind[1];

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    // Covers R4, R7 and R8: a matching read always leads to supply, never forward
    p_read_hit_takeover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (resp_valid && takeover && !fwd_valid));

    p_free_after_supply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_last) |=> (wr_ready && !fwd_valid));

    p_fwd_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && !fwd_valid && bus_grant && !rd_hit) |=> fwd_valid);

    p_no_dual_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && fwd_valid));

    p_illegal_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_hit);

endmodule

bind snoop_takeover_unit tkv_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .snoop_valid (snoop_valid),
    .snoop_kind  (snoop_kind),
    .snoop_addr  (snoop_addr),
    .bus_grant   (bus_grant),
    .takeover    (takeover),
    .resp_valid  (resp_valid),
    .resp_last   (resp_last),
    .fwd_valid   (fwd_valid)
);

// File: tb/snoop_takeover_unit_bench.sv
module snoop_takeover_unit_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int BEATS  = 4;
    localparam int LINE_W = BEATS * DATA_W;
    localparam int OFF_W  = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [LINE_W-1:0] wr_line = '0;
    logic              wr_ready;
    logic              snoop_valid = 1'b0;
    logic [1:0]        snoop_kind = 2'd0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              bus_grant = 1'b0;
    logic              takeover, resp_valid, resp_last, fwd_valid, fwd_last;
    logic [DATA_W-1:0] resp_data, fwd_data;
    logic [ADDR_W-1:0] fwd_addr;

    snoop_takeover_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_snoop_takeover_unit (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_line(wr_line),
        .wr_ready(wr_ready), .snoop_valid(snoop_valid), .snoop_kind(snoop_kind),
        .snoop_addr(snoop_addr), .bus_grant(bus_grant), .takeover(takeover),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_last(resp_last),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_last(fwd_last)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] beat_of(input logic [LINE_W-1:0] l, input int i);
        return l[i*DATA_W +: DATA_W];
    endfunction

    function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    function automatic logic [LINE_W-1:0] rand_line();
        logic [LINE_W-1:0] l;
        for (int k = 0; k < LINE_W / 32; k++) l[k*32 +: 32] = $urandom;
        return l;
    endfunction

    task automatic clear_inputs();
        wr_valid = 1'b0; snoop_valid = 1'b0; bus_grant = 1'b0;
    endtask

    task automatic drive_hit(input logic [ADDR_W-1:0] a);
        snoop_valid = 1'b1;
        snoop_kind  = 2'($urandom_range(0, 1));           // R4: either read kind
        snoop_addr  = align(a) | ADDR_W'($urandom_range(0, (1 << OFF_W) - 1)); // R3 offset ignored
    endtask

    // Expect BEATS supply beats, then a free unit and no forward (R4, R5)
    task automatic expect_supply(input logic [LINE_W-1:0] line);
        for (int i = 0; i < BEATS; i++) begin
            @(negedge clk);
            clear_inputs();
            chk(resp_valid && takeover, "R4 takeover/resp_valid", {takeover, resp_valid}, 2'b11);
            chk(resp_data == beat_of(line, i), "R4 resp_data beat", resp_data, beat_of(line, i));
            chk(resp_last == (i == BEATS - 1), "R4 resp_last", resp_last, (i == BEATS - 1));
            chk(!fwd_valid, "R7 no forward during supply", fwd_valid, 0);
        end
        @(negedge clk);
        chk(wr_ready && !resp_valid, "R5 free after supply", {wr_ready, resp_valid}, 2'b10);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk(!fwd_valid, "R5 discarded write never forwarded", fwd_valid, 0);
    endtask

    task automatic expect_fwd_beat(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] line,
                                   input int i);
        chk(fwd_valid && !resp_valid, "R6 fwd_valid", {fwd_valid, resp_valid}, 2'b10);
        chk(fwd_data == beat_of(line, i), "R6 fwd_data beat", fwd_data, beat_of(line, i));
        chk(fwd_addr == align(a), "R3 fwd_addr aligned", fwd_addr, align(a));
        chk(fwd_last == (i == BEATS - 1), "R6 fwd_last", fwd_last, (i == BEATS - 1));
    endtask

    // mode 0 grant, 1 read hit, 2 hit and grant together, 3 hit during forward
    task automatic run_case(input int mode);
        logic [ADDR_W-1:0] a    = $urandom;
        logic [LINE_W-1:0] line = rand_line();
        int gaps = $urandom_range(0, 3);
        chk(wr_ready, "R2 ready before issue", wr_ready, 1);
        wr_valid = 1'b1; wr_addr = a; wr_line = line;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(!wr_ready, "R2 busy after accept", wr_ready, 0);
        for (int g = 0; g < gaps; g++) begin
            int r = $urandom_range(0, 2);
            if (r == 0) begin          // R9: other line, any kind (R10 never provoked)
                snoop_valid = 1'b1;
                snoop_kind  = 2'($urandom_range(0, 3));
                snoop_addr  = a ^ (ADDR_W'(1) << $urandom_range(OFF_W, ADDR_W - 1));
            end else if (r == 1) begin // R9: matching read without qualifier
                snoop_valid = 1'b0; snoop_kind = 2'd0; snoop_addr = a;
            end else begin             // R2: write offered while busy
                wr_valid = 1'b1; wr_line = ~line; wr_addr = ~a;
            end
            @(negedge clk);
            clear_inputs();
            chk(!resp_valid && !fwd_valid && !wr_ready && !takeover, "R9 no effect while held",
                {resp_valid, fwd_valid, wr_ready, takeover}, 4'b0000);
        end
        case (mode)
            0: begin
                bus_grant = 1'b1;
                for (int i = 0; i < BEATS; i++) begin
                    @(negedge clk);
                    clear_inputs();
                    expect_fwd_beat(a, line, i);
                end
                @(negedge clk);
                chk(wr_ready && !fwd_valid, "R6 free after forward", {wr_ready, fwd_valid}, 2'b10);
            end
            1: begin
                drive_hit(a);
                expect_supply(line);
            end
            2: begin
                drive_hit(a);
                bus_grant = 1'b1;              // R8: snoop wins
                expect_supply(line);
            end
            default: begin
                int j = $urandom_range(0, BEATS - 1);
                bus_grant = 1'b1;
                for (int i = 0; i <= j; i++) begin
                    @(negedge clk);
                    clear_inputs();
                    expect_fwd_beat(a, line, i);
                end
                drive_hit(a);                  // R7: conflict during transfer
                expect_supply(line);
            end
        endcase
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(wr_ready && !takeover && !resp_valid && !fwd_valid, "R1 reset state",
            {wr_ready, takeover, resp_valid, fwd_valid}, 4'b1000);
        // R9: snoop while empty
        snoop_valid = 1'b1; snoop_kind = 2'd1; snoop_addr = $urandom;
        @(negedge clk);
        clear_inputs();
        chk(!resp_valid && !takeover && wr_ready, "R9 snoop while empty",
            {resp_valid, takeover, wr_ready}, 3'b001);
        for (int m = 0; m < 4; m++) run_case(m);
        for (int n = 0; n < 80; n++) run_case($urandom_range(0, 3));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule